// File: doc/BRIEF.md
# Two-Bit Accumulator Processor Core

This block is a very small stored-program processor with a 2-bit datapath. One memory of 2-bit words holds both the instructions and their operands. A single shared data bus links the memory, the instruction register, the accumulator, a B register and an output buffer. A controller walks each instruction through two fetch phases and one execute phase. In each phase it enables at most one bus source and the matching bus sinks.

The memory is read in strict address order by a separate memory address counter. The counter advances only on cycles that consume a word. Because the opcode is 3 bits wide and the bus is only 2 bits wide, each opcode takes two words.

The surrounding system fills the memory through a preload port, then releases reset. It watches the accumulator, the output buffer and the halt flag.

Top module: `tiny_acc_cpu`

## Requirements
- R1: While reset is asserted, and at the first cycle after it, `acc_o`, `out_o` and `halted_o` are zero. The program counter, memory address counter, B register, instruction register and phase are also zero.
- R2: When `pre_we` is high at a clock edge, the preload port writes `pre_data` into memory word `pre_addr`. This works in any state, including reset and halt. After reset the processor reads words starting at address 0.
- R3: An opcode spans two consecutive words. The first word gives opcode bits [1:0]. Bit 0 of the second word gives opcode bit 2. Every instruction takes exactly three cycles, and the accumulator does not change during the two fetch cycles.
- R4: Opcode 001 loads the next memory word into the accumulator. Opcode 010 loads the next memory word into B.
- R5: Opcode 011 reads the next memory word as an ALU select and writes the result into the accumulator, with A taken from the accumulator and B from the B register. The select codes are:
  - 11: A+B modulo 4
  - 10: NOR of A and B
  - 01: B
  - 00: compare, giving bit1 = (A>B) and bit0 = (A==B)
- R6: Opcode 100 copies the accumulator over the bus into the output buffer `out_o`. The accumulator is unchanged. The output buffer changes on no other instruction.
- R7: Opcode 101 raises `halted_o`. From then until the next reset, `halted_o`, `acc_o` and `out_o` stay constant, even if the memory is rewritten.
- R8: Opcodes 000, 110 and 111 consume only their two opcode words and change neither the accumulator nor the output buffer.
- R9: The 3-bit memory address counter wraps from 7 to 0. Execution continues across the wrap, and an instruction may straddle words 7 and 0.
- R10: In every cycle at most one source (memory or accumulator) drives the data bus.
- R11: The 2-bit program counter advances by one, modulo 4, at the end of every execute phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pre_we | input | 1 | Memory preload write strobe |
| pre_addr | input | 3 | Memory preload word address |
| pre_data | input | 2 | Memory preload word value |
| acc_o | output | 2 | Accumulator value |
| out_o | output | 2 | Output buffer written by the output instruction |
| halted_o | output | 1 | High once the halt instruction has executed |

## Verification
The hardest situation to reach from the ports is an instruction that straddles the wrap of the address counter, combined with arithmetic that overflows on repeated passes.

The stimulus fills all eight words so that the program loops forever. In the looping programs the output instruction shows a new value on every pass, so the bench follows each pass by watching `out_o` change rather than by counting cycles.

The no-op programs place the halt opcode across words 7 and 0. If a no-op wrongly consumed an extra word, the opcode alignment would shift and the expected halt and values would be missed.

// File: rtl/cpu2_pkg.sv
package cpu2_pkg;

  typedef enum logic [1:0] {
    PH_F0   = 2'd0,
    PH_F1   = 2'd1,
    PH_EX   = 2'd2,
    PH_HALT = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    ALU_CMP   = 2'b00,
    ALU_PASSB = 2'b01,
    ALU_NOR   = 2'b10,
    ALU_ADD   = 2'b11
  } alu_op_t;

  localparam logic [2:0] OPC_LDA = 3'b001;
  localparam logic [2:0] OPC_LDB = 3'b010;
  localparam logic [2:0] OPC_ALU = 3'b011;
  localparam logic [2:0] OPC_OUT = 3'b100;
  localparam logic [2:0] OPC_HLT = 3'b101;

  typedef struct packed {
    logic rom_oe;
    logic acc_oe;
    logic ir_lo_we;
    logic ir_hi_we;
    logic acc_ld_bus;
    logic acc_ld_alu;
    logic b_ld;
    logic buf_ld;
    logic mac_up;
    logic pc_up;
  } ctl_t;

endpackage

// File: rtl/cpu2_alu.sv
module cpu2_alu #(
  parameter int DW = 2
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [1:0]    op_i,
  output logic [DW-1:0] y_o
);
  import cpu2_pkg::*;

  always_comb begin
    y_o = '0;
    unique case (alu_op_t'(op_i))
      ALU_ADD:   y_o = a_i + b_i;
      ALU_NOR:   y_o = ~(a_i | b_i);
      ALU_PASSB: y_o = b_i;
      default: begin
        y_o[1] = (a_i > b_i);
        y_o[0] = (a_i == b_i);
      end
    endcase
  end
endmodule

// File: rtl/cpu2_rom.sv
module cpu2_rom #(
  parameter int DW = 2,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem_q [DEPTH];
  logic [DEPTH-1:0] word_sel;

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // one-hot address decoder
  for (genvar g = 0; g < DEPTH; g++) begin : g_dec
    assign word_sel[g] = (raddr_i == AW'(g));
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (word_sel[i]) rdata_o = rdata_o | mem_q[i];
    end
  end
endmodule

// File: rtl/cpu2_cnt.sv
module cpu2_cnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q_o;
    if (en_i) q_d = q_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_d;
  end
endmodule

// File: rtl/cpu2_ctrl.sv
module cpu2_ctrl (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        ir_i,
  output cpu2_pkg::phase_t  phase_o,
  output cpu2_pkg::ctl_t    ctl_o
);
  import cpu2_pkg::*;

  phase_t phase_d;

  always_comb begin
    ctl_o   = '0;
    phase_d = phase_o;
    unique case (phase_o)
      PH_F0: begin
        ctl_o.rom_oe   = 1'b1;
        ctl_o.ir_lo_we = 1'b1;
        ctl_o.mac_up   = 1'b1;
        phase_d        = PH_F1;
      end
      PH_F1: begin
        ctl_o.rom_oe   = 1'b1;
        ctl_o.ir_hi_we = 1'b1;
        ctl_o.mac_up   = 1'b1;
        phase_d        = PH_EX;
      end
      PH_EX: begin
        ctl_o.pc_up = 1'b1;
        phase_d     = PH_F0;
        case (ir_i)
          OPC_LDA: begin
            ctl_o.rom_oe     = 1'b1;
            ctl_o.acc_ld_bus = 1'b1;
            ctl_o.mac_up     = 1'b1;
          end
          OPC_LDB: begin
            ctl_o.rom_oe = 1'b1;
            ctl_o.b_ld   = 1'b1;
            ctl_o.mac_up = 1'b1;
          end
          OPC_ALU: begin
            ctl_o.rom_oe     = 1'b1;
            ctl_o.acc_ld_alu = 1'b1;
            ctl_o.mac_up     = 1'b1;
          end
          OPC_OUT: begin
            ctl_o.acc_oe = 1'b1;
            ctl_o.buf_ld = 1'b1;
          end
          OPC_HLT: phase_d = PH_HALT;
          default: ;
        endcase
      end
      default: phase_d = PH_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_o <= PH_F0;
    else        phase_o <= phase_d;
  end
endmodule

// File: rtl/tiny_acc_cpu.sv
module tiny_acc_cpu #(
  parameter int DW  = 2,
  parameter int AW  = 3,
  parameter int PCW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_we,
  input  logic [AW-1:0] pre_addr,
  input  logic [DW-1:0] pre_data,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] out_o,
  output logic          halted_o
);
  import cpu2_pkg::*;

  localparam int IRW = 3;

  logic           rst_meta_q, rst_q;
  phase_t         phase_q;
  ctl_t           ctl;
  logic [AW-1:0]  mac_q;
  logic [PCW-1:0] pc_q;
  logic [IRW-1:0] ir_q, ir_d;
  logic [DW-1:0]  acc_q, acc_d, b_q, b_d, buf_q, buf_d;
  logic [DW-1:0]  rom_rd, alu_y, bus;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  cpu2_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_q),
    .ir_i    (ir_d),
    .phase_o (phase_q),
    .ctl_o   (ctl)
  );

  cpu2_cnt #(.W(AW)) u_mac (
    .clk   (clk),
    .rst_n (rst_q),
    .en_i  (ctl.mac_up),
    .q_o   (mac_q)
  );

  cpu2_cnt #(.W(PCW)) u_pc (
    .clk   (clk),
    .rst_n (rst_q),
    .en_i  (ctl.pc_up),
    .q_o   (pc_q)
  );

  cpu2_rom #(.DW(DW), .AW(AW)) u_rom (
    .clk     (clk),
    .we_i    (pre_we),
    .waddr_i (pre_addr),
    .wdata_i (pre_data),
    .raddr_i (mac_q),
    .rdata_o (rom_rd)
  );

  cpu2_alu #(.DW(DW)) u_alu (
    .a_i  (acc_q),
    .b_i  (b_q),
    .op_i (bus[1:0]),
    .y_o  (alu_y)
  );

  // shared bus: enables from the controller select the single source
  always_comb begin
    bus = '0;
    if (ctl.rom_oe)      bus = rom_rd;
    else if (ctl.acc_oe) bus = acc_q;
  end

  always_comb begin
    ir_d  = ir_q;
    acc_d = acc_q;
    b_d   = b_q;
    buf_d = buf_q;
    if (ctl.ir_lo_we)   ir_d[1:0] = bus[1:0];
    if (ctl.ir_hi_we)   ir_d[2]   = bus[0];
    if (ctl.acc_ld_bus) acc_d     = bus;
    if (ctl.acc_ld_alu) acc_d     = alu_y;
    if (ctl.b_ld)       b_d       = bus;
    if (ctl.buf_ld)     buf_d     = bus;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ir_q  <= '0;
      acc_q <= '0;
      b_q   <= '0;
      buf_q <= '0;
    end else begin
      ir_q  <= ir_d;
      acc_q <= acc_d;
      b_q   <= b_d;
      buf_q <= buf_d;
    end
  end

  assign acc_o    = acc_q;
  assign out_o    = buf_q;
  assign halted_o = (phase_q == PH_HALT);

endmodule

// File: rtl/cpu2_chk.sv
module cpu2_chk #(
  parameter int DW  = 2,
  parameter int AW  = 3,
  parameter int PCW = 2
) (
  input logic             clk,
  input logic             rst_q,
  input cpu2_pkg::phase_t phase_q,
  input cpu2_pkg::ctl_t   ctl,
  input logic [AW-1:0]    mac_q,
  input logic [PCW-1:0]   pc_q,
  input logic [DW-1:0]    acc_o,
  input logic [DW-1:0]    out_o,
  input logic             halted_o
);
  import cpu2_pkg::*;

  assert_bus_single_R10: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({ctl.rom_oe, ctl.acc_oe}));

  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_q)
    halted_o |=> halted_o);

  assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_q)
    halted_o |=> ($stable(acc_o) && $stable(out_o)));

  assert_fetch_keeps_acc_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (phase_q == PH_F0 || phase_q == PH_F1) |=> $stable(acc_o));

  assert_out_only_exec_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (phase_q != PH_EX) |=> $stable(out_o));

  assert_mac_step_R9: assert property (@(posedge clk) disable iff (!rst_q)
    ctl.mac_up |=> (mac_q == AW'($past(mac_q) + 1'b1)));

  assert_pc_step_R11: assert property (@(posedge clk) disable iff (!rst_q)
    (phase_q == PH_EX) |=> (pc_q == PCW'($past(pc_q) + 1'b1)));
endmodule

bind tiny_acc_cpu cpu2_chk #(.DW(DW), .AW(AW), .PCW(PCW)) u_chk (
  .clk      (clk),
  .rst_q    (rst_q),
  .phase_q  (phase_q),
  .ctl      (ctl),
  .mac_q    (mac_q),
  .pc_q     (pc_q),
  .acc_o    (acc_o),
  .out_o    (out_o),
  .halted_o (halted_o)
);

// File: tb/tiny_acc_cpu_tb.sv
module tiny_acc_cpu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pre_we = 1'b0;
  logic [2:0] pre_addr = '0;
  logic [1:0] pre_data = '0;
  logic [1:0] acc_o, out_o;
  logic       halted_o;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  tiny_acc_cpu u_dut (
    .clk (clk), .rst_n (rst_n), .pre_we (pre_we), .pre_addr (pre_addr),
    .pre_data (pre_data), .acc_o (acc_o), .out_o (out_o), .halted_o (halted_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // hold reset, preload 8 words, release reset
  task automatic start_prog(input logic [1:0] w0, w1, w2, w3, w4, w5, w6, w7);
    logic [1:0] w [8];
    w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3;
    w[4] = w4; w[5] = w5; w[6] = w6; w[7] = w7;
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      pre_we   = 1'b1;
      pre_addr = 3'(i);
      pre_data = w[i];
      @(negedge clk);
    end
    pre_we = 1'b0;
    rst_n  = 1'b1;
  endtask

  task automatic run_halt(output logic ok);
    ok = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (halted_o) begin
        ok = 1'b1;
        return;
      end
    end
  endtask

  task automatic wait_change(input logic [1:0] prev, output logic [1:0] nv);
    nv = prev;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (out_o !== prev) begin
        nv = out_o;
        return;
      end
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 acc in reset", acc_o, 2'd0);
    chk("R1 out in reset", out_o, 2'd0);
    chk("R1 halted in reset", {1'b0, halted_o}, 2'd0);
  endtask

  // LDA 2 ; OUT ; HLT
  task automatic test_lda_out();
    logic ok;
    start_prog(2'b01, 2'b00, 2'b10, 2'b00, 2'b01, 2'b01, 2'b01, 2'b00);
    @(negedge clk);
    chk("R1 out just after reset release", out_o, 2'd0);
    run_halt(ok);
    chk("R3 split opcode fetch reaches halt", {1'b0, ok}, 2'd1);
    chk("R4 LDA value", acc_o, 2'd2);
    chk("R6 OUT copies acc", out_o, 2'd2);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = 3'd2; pre_data = 2'b11;
    @(negedge clk);
    pre_we = 1'b0;
    repeat (20) @(negedge clk);
    chk("R7 acc held after halt", acc_o, 2'd2);
    chk("R7 out held after halt", out_o, 2'd2);
    chk("R7 halted sticky", {1'b0, halted_o}, 2'd1);
  endtask

  // loop: LDB 3 ; ALU add ; OUT  (exactly 8 words, wraps)
  task automatic test_add_loop();
    logic [1:0] v;
    start_prog(2'b10, 2'b00, 2'b11, 2'b11, 2'b00, 2'b11, 2'b00, 2'b01);
    wait_change(2'd0, v); chk("R5 add 0+3", v, 2'd3);
    wait_change(v, v);    chk("R9 second pass after wrap 3+3", v, 2'd2);
    wait_change(v, v);    chk("R5 add 2+3 mod 4", v, 2'd1);
    wait_change(v, v);    chk("R5 add 1+3 overflow", v, 2'd0);
  endtask

  // loop: LDB 1 ; ALU nor ; OUT
  task automatic test_nor_loop();
    logic [1:0] v;
    start_prog(2'b10, 2'b00, 2'b01, 2'b11, 2'b00, 2'b10, 2'b00, 2'b01);
    wait_change(2'd0, v); chk("R5 nor(0,1)", v, 2'd2);
    wait_change(v, v);    chk("R5 nor(2,1)", v, 2'd0);
  endtask

  task automatic test_passb();
    logic ok;
    // LDB 2 ; ALU passB ; HLT
    start_prog(2'b10, 2'b00, 2'b10, 2'b11, 2'b00, 2'b01, 2'b01, 2'b01);
    run_halt(ok);
    chk("R2 R4 LDB preloaded operand then passB", acc_o, 2'd2);
    // LDA 3 ; ALU passB ; HLT  (B reset to 0)
    start_prog(2'b01, 2'b00, 2'b11, 2'b11, 2'b00, 2'b01, 2'b01, 2'b01);
    run_halt(ok);
    chk("R5 passB overwrites acc", acc_o, 2'd0);
    chk("R6 out untouched without OUT", out_o, 2'd0);
  endtask

  task automatic test_cmp();
    logic ok;
    // LDA 1 ; ALU cmp ; HLT  -> A>B
    start_prog(2'b01, 2'b00, 2'b01, 2'b11, 2'b00, 2'b00, 2'b01, 2'b01);
    run_halt(ok);
    chk("R5 compare greater", acc_o, 2'b10);
    // LDA 0 ; ALU cmp ; HLT  -> equal
    start_prog(2'b01, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 2'b01, 2'b01);
    run_halt(ok);
    chk("R5 compare equal", acc_o, 2'b01);
    // LDB 2 ; ALU cmp ; HLT  -> less
    start_prog(2'b10, 2'b00, 2'b10, 2'b11, 2'b00, 2'b00, 2'b01, 2'b01);
    run_halt(ok);
    chk("R5 compare less", acc_o, 2'b00);
  endtask

  // LDA 3 ; unused op ; OUT ; HLT straddling words 7 and 0
  task automatic test_nop(input logic op_hi_lo);
    logic ok;
    start_prog(2'b01, 2'b00, 2'b11, op_hi_lo ? 2'b11 : 2'b10, 2'b01,
               2'b00, 2'b01, 2'b01);
    run_halt(ok);
    chk("R8 R9 unused opcode keeps alignment, halt over wrap", {1'b0, ok}, 2'd1);
    chk("R8 acc kept across unused opcode", acc_o, 2'd3);
    chk("R8 out after unused opcode", out_o, 2'd3);
  endtask

  initial begin
    test_reset();
    test_lda_out();
    test_add_loop();
    test_nor_loop();
    test_passb();
    test_cmp();
    test_nop(1'b0);
    test_nop(1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule